// File: doc/BRIEF.md
# Privilege-Filtered Event Counter Bank with Overflow Freeze

This block holds a small bank of generic event counters for performance monitoring. Each counter has a configuration register and a data register on a simple register bus. A configuration register selects one of the incoming event strobes and gives a mask of the privilege levels at which counting is allowed. On each clock edge where the selected strobe is high, the current privilege level is enabled and monitoring is not frozen, the counter adds one.

When a counter wraps from all ones to zero, it sets its own sticky overflow bit in a shared status register. It can also pulse an external overflow output for that counter. If its interrupt enable is set, the wrap also sets a global freeze bit that stops every counter. It then raises one interrupt pulse, provided that counter's overflow bit was still clear.

Software re-arms the interrupt by clearing the overflow bit, either before the freeze bit or in the same write. Clearing only the freeze bit lets counting resume, but a further wrap of that counter gives no new interrupt.

Top module: `evctr_bank`

## Requirements
- R1: After reset every register reads zero, and `irq` and `ext_ovf` are low.
- R2: Register map: address 0 is status, address 2+2i is configuration of counter i, address 3+2i is data of counter i. Any other address reads zero. The data register keeps bits CNT_W-1:0. Writes to its bits 63:CNT_W are ignored, and those bits read zero.
- R3: Configuration fields: bits 3:0 privilege mask (bit n enables level n), bit 4 external overflow enable, bit 5 interrupt enable, bit 6 privileged-monitor flag (stored only), bits 15:8 event select. All other bits ignore writes and read zero.
- R4: A counter adds one at a clock edge only when `event_in[select]` is high, mask bit `priv_lvl` is 1 and freeze is 0. A select value of NEV or more never counts.
- R5: A wrap from all ones to zero sets status bit i+1 (the overflow bit of counter i), whatever the enables. The bit stays set until software writes 0 to it. A hardware set in the same cycle as a software write wins.
- R6: When configuration bit 4 is set, `ext_ovf[i]` is high for the one cycle after the edge at which counter i wraps.
- R7: When configuration bit 5 is set, a wrap sets status bit 0 (freeze). If the counter's overflow bit was clear, the wrap also drives `irq` high for exactly one cycle. When bit 5 is clear, a wrap raises no interrupt and leaves freeze unchanged.
- R8: While freeze is 1, no counter changes on events. Software may write freeze directly. Freeze stops counting from the edge after the wrap.
- R9: If software clears freeze but leaves a counter's overflow bit set, a later wrap of that counter raises no interrupt. Once the overflow bit is cleared, a wrap interrupts again.
- R10: A data-register write in the same cycle as an event loads the written value, and the increment is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | AW | Write address |
| reg_wdata | input | 64 | Write data |
| reg_raddr | input | AW | Read address |
| reg_rdata | output | 64 | Read data for `reg_raddr` (combinational) |
| event_in | input | NEV | Event strobes, one per event number |
| priv_lvl | input | 2 | Current privilege level |
| irq | output | 1 | One-cycle overflow interrupt pulse |
| ext_ovf | output | NCTR | Per-counter external overflow pulse |

## Verification
Random event strobes and privilege levels run against random configurations, including out-of-range selects and empty masks. This tells apart errors in the event selection from errors in the privilege filter. Data writes are biased to values just below the wrap point, so overflows happen often. Those overflows mix interrupt-enabled and silent counters and separate the sticky-bit path from the freeze and interrupt paths.

Directed sequences cover three things:
- re-arming with freeze cleared alone versus together with the overflow bit, which tells the edge-style interrupt apart from a level one;
- a data write that collides with an event;
- write data with junk in the ignored upper bits.

// File: rtl/evctr_pkg.sv
package evctr_pkg;

  // Stored configuration fields, packed so that the struct lines up with
  // {word[15:8], word[6:0]} of a configuration write.
  typedef struct packed {
    logic [7:0] evsel;
    logic       pmon;
    logic       irq_en;
    logic       ext_en;
    logic [3:0] plm;
  } evctr_cfg_t;

  localparam int CFG_BITS = $bits(evctr_cfg_t);

  function automatic evctr_cfg_t cfg_from_word(input logic [15:0] w);
    return evctr_cfg_t'({w[15:8], w[6:0]});
  endfunction

  function automatic logic [63:0] cfg_to_word(input evctr_cfg_t c);
    logic [63:0] w;
    w       = '0;
    w[15:8] = c.evsel;
    w[6:0]  = {c.pmon, c.irq_en, c.ext_en, c.plm};
    return w;
  endfunction

endpackage

// File: rtl/evctr_slot.sv
module evctr_slot
  import evctr_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int NEV   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cnt_we,
  input  logic [15:0]      cfg_wd,
  input  logic [CNT_W-1:0] cnt_wd,
  input  logic [NEV-1:0]   event_in,
  input  logic [1:0]       priv_lvl,
  input  logic             frozen,
  output evctr_cfg_t       cfg_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             inc,
  output logic             carry
);

  logic             ev_hit;
  logic [CNT_W:0]   sum;

  // Event select: values at or above NEV match nothing.
  always_comb begin
    ev_hit = 1'b0;
    for (int e = 0; e < NEV; e++) begin
      if (cfg_q.evsel == 8'(e)) ev_hit = event_in[e];
    end
  end

  // A software data write takes priority, so the increment is dropped.
  assign inc   = ev_hit & cfg_q.plm[priv_lvl] & ~frozen & ~cnt_we;
  assign sum   = {1'b0, cnt_q} + (CNT_W+1)'(1);
  assign carry = inc & sum[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
    end else begin
      if (cfg_we) cfg_q <= cfg_from_word(cfg_wd);
      if (cnt_we)   cnt_q <= cnt_wd;
      else if (inc) cnt_q <= sum[CNT_W-1:0];
    end
  end

endmodule

// File: rtl/evctr_ctl.sv
module evctr_ctl #(
  parameter int NCTR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stat_we,
  input  logic [NCTR:0]   stat_wd,
  input  logic [NCTR-1:0] carry,
  input  logic [NCTR-1:0] irq_en,
  input  logic [NCTR-1:0] ext_en,
  output logic            frz_q,
  output logic [NCTR-1:0] ovf_q,
  output logic            irq,
  output logic [NCTR-1:0] ext_ovf
);

  logic [NCTR-1:0] ovf_n;
  logic            frz_n;
  logic [NCTR-1:0] fresh_ovf;

  // Hardware sets win over a concurrent software write.
  always_comb begin
    ovf_n     = (stat_we ? stat_wd[NCTR:1] : ovf_q) | carry;
    frz_n     = (stat_we ? stat_wd[0] : frz_q) | (|(carry & irq_en));
    fresh_ovf = carry & irq_en & ~ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q   <= 1'b0;
      ovf_q   <= '0;
      irq     <= 1'b0;
      ext_ovf <= '0;
    end else begin
      frz_q   <= frz_n;
      ovf_q   <= ovf_n;
      irq     <= |fresh_ovf;
      ext_ovf <= carry & ext_en;
    end
  end

endmodule

// File: rtl/evctr_bank.sv
module evctr_bank
  import evctr_pkg::*;
#(
  parameter int NCTR  = 4,
  parameter int CNT_W = 32,
  parameter int NEV   = 8,
  localparam int NREG = 2 * NCTR + 2,
  localparam int AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_waddr,
  input  logic [63:0]     reg_wdata,
  input  logic [AW-1:0]   reg_raddr,
  output logic [63:0]     reg_rdata,
  input  logic [NEV-1:0]  event_in,
  input  logic [1:0]      priv_lvl,
  output logic            irq,
  output logic [NCTR-1:0] ext_ovf
);

  logic                        stat_we;
  logic [NCTR-1:0]             cfg_we;
  logic [NCTR-1:0]             cnt_we;
  logic [NCTR-1:0]             carry;
  logic [NCTR-1:0]             inc;
  logic [NCTR-1:0]             irq_en;
  logic [NCTR-1:0]             ext_en;
  logic [NCTR-1:0][CNT_W-1:0]  cnt_all;
  evctr_cfg_t                  cfg_all [NCTR];
  logic                        frz_q;
  logic [NCTR-1:0]             ovf_q;
  logic                        unused_wbits;

  assign unused_wbits = ^{reg_wdata[63:16], reg_wdata[7]};
  assign stat_we      = reg_wr && (reg_waddr == '0);

  for (genvar i = 0; i < NCTR; i++) begin : g_slot
    assign cfg_we[i] = reg_wr && (reg_waddr == AW'(2 + 2 * i));
    assign cnt_we[i] = reg_wr && (reg_waddr == AW'(3 + 2 * i));
    assign irq_en[i] = cfg_all[i].irq_en;
    assign ext_en[i] = cfg_all[i].ext_en;

    evctr_slot #(.CNT_W(CNT_W), .NEV(NEV)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we[i]),
      .cnt_we   (cnt_we[i]),
      .cfg_wd   (reg_wdata[15:0]),
      .cnt_wd   (reg_wdata[CNT_W-1:0]),
      .event_in (event_in),
      .priv_lvl (priv_lvl),
      .frozen   (frz_q),
      .cfg_q    (cfg_all[i]),
      .cnt_q    (cnt_all[i]),
      .inc      (inc[i]),
      .carry    (carry[i])
    );
  end

  evctr_ctl #(.NCTR(NCTR)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .stat_we (stat_we),
    .stat_wd (reg_wdata[NCTR:0]),
    .carry   (carry),
    .irq_en  (irq_en),
    .ext_en  (ext_en),
    .frz_q   (frz_q),
    .ovf_q   (ovf_q),
    .irq     (irq),
    .ext_ovf (ext_ovf)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == '0) reg_rdata[NCTR:0] = {ovf_q, frz_q};
    for (int i = 0; i < NCTR; i++) begin
      if (reg_raddr == AW'(2 + 2 * i)) reg_rdata = cfg_to_word(cfg_all[i]);
      if (reg_raddr == AW'(3 + 2 * i)) reg_rdata[CNT_W-1:0] = cnt_all[i];
    end
  end

endmodule

// File: rtl/evctr_bank_chk.sv
module evctr_bank_chk #(
  parameter int NCTR  = 4,
  parameter int CNT_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       irq,
  input logic                       frz_q,
  input logic [NCTR-1:0]            ovf_q,
  input logic                       stat_we,
  input logic [NCTR-1:0]            cnt_we,
  input logic [NCTR-1:0]            ext_ovf,
  input logic [NCTR-1:0][CNT_W-1:0] cnt_all
);

  // R7: the interrupt is a single-cycle pulse
  a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R7: an interrupt always comes with freeze set
  a_r7_irq_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> frz_q);

  // R7: an interrupt always comes with some overflow bit set
  a_r7_irq_has_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_q != '0));

  for (genvar i = 0; i < NCTR; i++) begin : g_chk
    // R5: overflow bits stay set unless status is written
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q[i] && !stat_we) |=> ovf_q[i]);

    // R8: frozen counters hold unless software writes them
    a_r8_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_q && !cnt_we[i]) |=> $stable(cnt_all[i]));

    // R6: an external pulse is accompanied by the overflow bit
    a_r6_ext_with_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      ext_ovf[i] |-> ovf_q[i]);
  end

endmodule

bind evctr_bank evctr_bank_chk #(.NCTR(NCTR), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .frz_q   (frz_q),
  .ovf_q   (ovf_q),
  .stat_we (stat_we),
  .cnt_we  (cnt_we),
  .ext_ovf (ext_ovf),
  .cnt_all (cnt_all)
);

// File: tb/evctr_bank_bench.sv
module evctr_bank_bench;
  localparam int CLK_P = 10;
  localparam int NC    = 4;
  localparam int CW    = 32;
  localparam int NE    = 8;
  localparam logic [63:0] CFG_KEEP = 64'h0000_0000_0000_FF7F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_waddr = '0;
  logic [63:0] reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [63:0] reg_rdata;
  logic [7:0]  event_in = '0;
  logic [1:0]  priv_lvl = '0;
  logic        irq;
  logic [3:0]  ext_ovf;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state
  logic [CW-1:0] m_cnt [NC];
  logic [63:0]   m_cfg [NC];
  logic [NC-1:0] m_ovf, m_ext;
  logic          m_frz, m_irq;
  logic [63:0]   obs_rdata;
  logic          obs_irq;
  logic [3:0]    obs_ext;

  evctr_bank #(.NCTR(NC), .CNT_W(CW), .NEV(NE)) u_evctr_bank (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .event_in(event_in), .priv_lvl(priv_lvl), .irq(irq), .ext_ovf(ext_ovf)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [63:0] exp_read(input logic [3:0] a);
    logic [63:0] v;
    v = '0;
    if (a == 4'd0) v[4:0] = {m_ovf, m_frz};
    for (int i = 0; i < NC; i++) begin
      if (a == 4'(2 + 2 * i)) v = m_cfg[i];
      if (a == 4'(3 + 2 * i)) v = {32'h0, m_cnt[i]};
    end
    return v;
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    if (a == 4'd0) return "R5 status";
    if (a >= 4'd10 || a == 4'd1) return "R2 unmapped";
    if (a[0] == 1'b0) return "R3 config";
    return "R4 data";
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic w, input logic [3:0] wa, input logic [63:0] wd,
                            input logic [7:0] ev, input logic [1:0] pl);
    logic [NC-1:0] nov, next;
    logic nfz, nirq;
    nov = m_ovf; nfz = m_frz; nirq = 1'b0; next = '0;
    if (w && wa == 4'd0) begin nfz = wd[0]; nov = wd[4:1]; end
    for (int i = 0; i < NC; i++) begin
      logic [7:0] sel;
      logic hit, dw, cw, step_up;
      sel = m_cfg[i][15:8];
      hit = (sel < 8'(NE)) ? ev[sel[2:0]] : 1'b0;
      dw  = w && (wa == 4'(3 + 2 * i));
      cw  = w && (wa == 4'(2 + 2 * i));
      step_up = hit && m_cfg[i][pl] && !m_frz && !dw;
      if (step_up && m_cnt[i] == '1) begin
        nov[i] = 1'b1;
        if (m_cfg[i][4]) next[i] = 1'b1;
        if (m_cfg[i][5]) begin
          nfz = 1'b1;
          if (!m_ovf[i]) nirq = 1'b1;
        end
      end
      if (dw) m_cnt[i] = wd[CW-1:0];
      else if (step_up) m_cnt[i] = m_cnt[i] + 1'b1;
      if (cw) m_cfg[i] = wd & CFG_KEEP;
    end
    m_ovf = nov; m_frz = nfz; m_irq = nirq; m_ext = next;
  endtask

  task automatic step(input logic w, input logic [3:0] wa, input logic [63:0] wd,
                      input logic [7:0] ev, input logic [1:0] pl, input logic [3:0] ra);
    @(negedge clk);
    reg_wr = w; reg_waddr = wa; reg_wdata = wd;
    event_in = ev; priv_lvl = pl; reg_raddr = ra;
    #1;
    obs_rdata = reg_rdata; obs_irq = irq; obs_ext = ext_ovf;
    chk(tag_of(ra), reg_rdata, exp_read(ra));
    chk("R7 irq", {63'h0, irq}, {63'h0, m_irq});
    chk("R6 ext_ovf", {60'h0, ext_ovf}, {60'h0, m_ext});
    @(posedge clk);
    model_edge(w, wa, wd, ev, pl);
  endtask

  task automatic idle(input logic [3:0] ra);
    step(1'b0, 4'd0, 64'h0, 8'h0, 2'd0, ra);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin m_cnt[i] = '0; m_cfg[i] = '0; end
    m_ovf = '0; m_ext = '0; m_frz = 1'b0; m_irq = 1'b0;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: everything reads zero after reset
    for (int a = 0; a < 16; a++) begin
      idle(4'(a));
      chk("R1 reset read", obs_rdata, 64'h0);
    end
    chk("R1 reset irq", {63'h0, obs_irq}, 64'h0);

    // R3: config write with junk in ignored bits; level 2 only, ext+irq, select 3
    step(1'b1, 4'd2, 64'hABCD_0000_0012_03B4, 8'h0, 2'd0, 4'd2);
    idle(4'd2);
    chk("R3 config fields", obs_rdata, 64'h0000_0000_0000_0334);
    // R2: upper data bits dropped
    step(1'b1, 4'd3, 64'hFFFF_FFFF_FFFF_FFFE, 8'h0, 2'd0, 4'd3);
    idle(4'd3);
    chk("R2 data upper bits", obs_rdata, 64'h0000_0000_FFFF_FFFE);
    // R4: privilege level 1 masked off
    step(1'b0, 4'd0, 64'h0, 8'h08, 2'd1, 4'd3);
    idle(4'd3);
    chk("R4 masked level", obs_rdata, 64'h0000_0000_FFFF_FFFE);
    step(1'b0, 4'd0, 64'h0, 8'h08, 2'd2, 4'd3);
    idle(4'd3);
    chk("R4 counted", obs_rdata, 64'h0000_0000_FFFF_FFFF);
    // wrap
    step(1'b0, 4'd0, 64'h0, 8'h08, 2'd2, 4'd3);
    idle(4'd0);
    chk("R7 irq on wrap", {63'h0, obs_irq}, 64'h1);
    chk("R6 ext on wrap", {60'h0, obs_ext}, 64'h1);
    chk("R5 status after wrap", obs_rdata, 64'h3);
    idle(4'd0);
    chk("R7 irq one cycle", {63'h0, obs_irq}, 64'h0);
    // R8: frozen, events ignored
    repeat (3) step(1'b0, 4'd0, 64'h0, 8'h08, 2'd2, 4'd3);
    idle(4'd3);
    chk("R8 frozen count", obs_rdata, 64'h0);
    // R9: clear freeze only, keep overflow bit
    step(1'b1, 4'd0, 64'h2, 8'h0, 2'd0, 4'd0);
    step(1'b1, 4'd3, 64'hFFFF_FFFF, 8'h0, 2'd0, 4'd0);
    step(1'b0, 4'd0, 64'h0, 8'h08, 2'd2, 4'd0);
    idle(4'd0);
    chk("R9 no irq while ovf set", {63'h0, obs_irq}, 64'h0);
    chk("R9 freeze set again", obs_rdata, 64'h3);
    // R9: clear both together re-arms
    step(1'b1, 4'd0, 64'h0, 8'h0, 2'd0, 4'd0);
    step(1'b1, 4'd3, 64'hFFFF_FFFF, 8'h0, 2'd0, 4'd0);
    step(1'b0, 4'd0, 64'h0, 8'h08, 2'd2, 4'd0);
    idle(4'd0);
    chk("R9 irq after re-arm", {63'h0, obs_irq}, 64'h1);
    // R10: write collides with event
    step(1'b1, 4'd0, 64'h0, 8'h0, 2'd0, 4'd0);
    step(1'b1, 4'd3, 64'h5, 8'h08, 2'd2, 4'd3);
    idle(4'd3);
    chk("R10 write wins", obs_rdata, 64'h5);
    // R4: select out of range never counts
    step(1'b1, 4'd4, 64'h0000_0000_0000_C80F, 8'h0, 2'd0, 4'd0);
    repeat (4) step(1'b0, 4'd0, 64'h0, 8'hFF, 2'd3, 4'd5);
    idle(4'd5);
    chk("R4 select out of range", obs_rdata, 64'h0);

    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      logic w;
      logic [3:0] wa;
      logic [63:0] wd;
      w  = ($urandom_range(0, 4) == 0);
      wa = 4'($urandom_range(0, 9));
      wd = {$urandom, $urandom};
      if (wa == 4'd0) begin
        wd[0] = ($urandom_range(0, 4) == 0);
        if ($urandom_range(0, 1) == 0) wd[4:1] = 4'h0;
      end else if (wa[0]) begin
        if ($urandom_range(0, 1) == 0) wd[31:0] = 32'hFFFF_FFF0 | 32'($urandom_range(0, 15));
      end else begin
        wd[15:8] = 8'($urandom_range(0, 9));
      end
      step(w, wa, wd, 8'($urandom), 2'($urandom), 4'($urandom));
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule